// File: doc/BRIEF.md
# Ingress Header Parser

This block terminates the receive side of one switch-fabric port. Bytes arrive one per cycle on a valid/ready stream from the serial front end. The block reads a compact three-byte header at the start of each packet. Byte 0 carries a command in bits [7:2] and a size code in bits [1:0]. Byte 1 is the destination port and byte 2 is the source. The block then keeps the whole packet, header included, in a one-packet local buffer.

Once the packet is complete, the port offers it to the central router. The port supplies the destination port number and the byte length alongside the data. The router therefore never parses headers or holds whole packets. It drains the buffer one byte per handshake, and the port then accepts the next packet. A packet addressed to a port number that does not exist is consumed, flagged and thrown away. Bytes that arrive while a finished packet is still held are dropped and counted.

Top module: `ingress_hdr_parser`

## Requirements
- R1: The size code in bits [1:0] of byte 0 selects the packet length: 0 gives 128, 1 gives 256, 2 gives 512 and 3 gives 1024 bytes. The header is included in that length, and `rtr_len_o` reports this length. Command bits [7:2] have no effect on the length.
- R2: Byte 1 of the packet is reported on `rtr_dest_o` for as long as the packet is offered.
- R3: `in_ready_o` is low from the cycle after the last byte of a legal packet is accepted until the last router handshake of that packet. While the packet is offered, `in_ready_o` stays low.
- R4: `rtr_valid_o` rises only after the whole packet has been received. The bytes come out in arrival order. `rtr_data_o` holds its value while `rtr_valid_o` is high and `rtr_ready_i` is low.
- R5: `rtr_last_o` is high with the final byte of the packet (index length-1) and with no other byte.
- R6: In each cycle where `in_valid_i` is high and `in_ready_o` is low, the byte is discarded and `drop_cnt_o` rises by one. The counter saturates at its maximum. Discarded bytes never reach the router.
- R7: A destination at or above the number of ports (default 4) causes the following. `dest_err_o` is high for exactly one cycle, the cycle after the last byte of that packet is accepted. The packet is never offered to the router, and `in_ready_o` stays high.
- R8: After reset, `in_ready_o` is 1 and `rtr_valid_o`, `dest_err_o` and `drop_cnt_o` are 0.
- R9: `in_ready_o` is high in the cycle after the final router handshake. A byte presented in the same cycle as that handshake is dropped and counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Incoming byte valid |
| in_data_i | input | 8 | Incoming byte |
| in_ready_o | output | 1 | Port can accept a byte |
| rtr_valid_o | output | 1 | Buffered byte offered to router |
| rtr_ready_i | input | 1 | Router takes the offered byte |
| rtr_data_o | output | 8 | Offered byte |
| rtr_last_o | output | 1 | Offered byte is the final one of the packet |
| rtr_dest_o | output | DEST_W (2) | Destination port of the held packet |
| rtr_len_o | output | LEN_W (11) | Byte length of the held packet |
| dest_err_o | output | 1 | One-cycle pulse for an illegal destination |
| drop_cnt_o | output | DROP_W (16) | Saturating count of dropped bytes |

## Verification
Two functions of this block can fall in the same cycle: the router's final handshake, which frees the buffer, and a new input byte. At that edge the port is still not ready, so the byte must be counted as a drop and must not be stored. The bench provokes this by raising `in_valid_i` exactly when `rtr_last_o` is offered with the router ready. It then checks that the drop count rises by one and that ready returns in the next cycle. It also checks that the following packet reaches the scoreboard intact, without the stray byte.

// File: rtl/ihp_pkg.sv
package ihp_pkg;

  typedef enum logic {
    ST_RECV  = 1'b0,
    ST_DRAIN = 1'b1
  } ihp_state_e;

  // header byte positions decoded by the port
  localparam int unsigned HDR_SIZE_IDX = 0;
  localparam int unsigned HDR_DEST_IDX = 1;

  function automatic int unsigned size_to_len(input logic [1:0] code,
                                              input int unsigned min_log2);
    return 32'd1 << (min_log2 + 32'(code));
  endfunction

endpackage

// File: rtl/ihp_hdr_decode.sv
module ihp_hdr_decode
  import ihp_pkg::*;
#(
  parameter int unsigned MIN_LEN_LOG2 = 7,
  parameter int unsigned IDX_W        = 10,
  parameter int unsigned LEN_W        = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             byte_en_i,
  input  logic [IDX_W-1:0] byte_idx_i,
  input  logic [7:0]       byte_i,
  output logic [7:0]       dest_o,
  output logic [LEN_W-1:0] len_o
);

  logic [1:0] size_q;
  logic [7:0] dest_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      size_q <= '0;
      dest_q <= '0;
    end else if (byte_en_i) begin
      if (byte_idx_i == IDX_W'(HDR_SIZE_IDX)) size_q <= byte_i[1:0];
      if (byte_idx_i == IDX_W'(HDR_DEST_IDX)) dest_q <= byte_i;
    end
  end

  assign dest_o = dest_q;
  assign len_o  = LEN_W'(size_to_len(size_q, MIN_LEN_LOG2));

  AST_LEN_POW2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(len_o) == 1); // R1

endmodule

// File: rtl/ihp_pkt_buf.sv
module ihp_pkt_buf #(
  parameter int unsigned DEPTH = 1024,
  parameter int unsigned PTR_W = 10
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [PTR_W-1:0] waddr_i,
  input  logic [7:0]       wdata_i,
  input  logic [PTR_W-1:0] raddr_i,
  output logic [7:0]       rdata_o
);

  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];

endmodule

// File: rtl/ihp_drop_ctr.sv
module ihp_drop_ctr #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         hit_i,
  output logic [W-1:0] count_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (hit_i && cnt_q != '1)  cnt_q <= cnt_q + 1'b1;
  end

  assign count_o = cnt_q;

  AST_DROP_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_i && count_o != '1 |=> count_o == $past(count_o) + 1'b1); // R6
  AST_DROP_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_i |=> $stable(count_o)); // R6

endmodule

// File: rtl/ingress_hdr_parser.sv
module ingress_hdr_parser
  import ihp_pkg::*;
#(
  parameter int unsigned NUM_PORTS    = 4,
  parameter int unsigned MIN_LEN_LOG2 = 7,
  parameter int unsigned DROP_W       = 16,
  localparam int unsigned MAX_LEN     = 1 << (MIN_LEN_LOG2 + 3),
  localparam int unsigned PTR_W       = $clog2(MAX_LEN),
  localparam int unsigned LEN_W       = PTR_W + 1,
  localparam int unsigned DEST_W      = $clog2(NUM_PORTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [7:0]        in_data_i,
  output logic              in_ready_o,
  output logic              rtr_valid_o,
  input  logic              rtr_ready_i,
  output logic [7:0]        rtr_data_o,
  output logic              rtr_last_o,
  output logic [DEST_W-1:0] rtr_dest_o,
  output logic [LEN_W-1:0]  rtr_len_o,
  output logic              dest_err_o,
  output logic [DROP_W-1:0] drop_cnt_o
);

  localparam logic [7:0] PORT_LIM = 8'(NUM_PORTS);

  ihp_state_e       state_q;
  logic [PTR_W-1:0] wr_cnt_q, rd_ptr_q;
  logic             err_q;
  logic [7:0]       dest;
  logic [LEN_W-1:0] len, len_m1;
  logic             in_acc, in_last, out_hs, dest_ok;

  assign in_ready_o  = (state_q == ST_RECV);
  assign rtr_valid_o = (state_q == ST_DRAIN);
  assign in_acc      = in_valid_i && in_ready_o;
  assign out_hs      = rtr_valid_o && rtr_ready_i;
  assign len_m1      = len - LEN_W'(1);
  assign in_last     = ({1'b0, wr_cnt_q} == len_m1);
  assign dest_ok     = dest < PORT_LIM;

  ihp_hdr_decode #(
    .MIN_LEN_LOG2(MIN_LEN_LOG2),
    .IDX_W       (PTR_W),
    .LEN_W       (LEN_W)
  ) u_dec (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .byte_en_i (in_acc),
    .byte_idx_i(wr_cnt_q),
    .byte_i    (in_data_i),
    .dest_o    (dest),
    .len_o     (len)
  );

  ihp_pkt_buf #(
    .DEPTH(MAX_LEN),
    .PTR_W(PTR_W)
  ) u_buf (
    .clk_i  (clk_i),
    .we_i   (in_acc),
    .waddr_i(wr_cnt_q),
    .wdata_i(in_data_i),
    .raddr_i(rd_ptr_q),
    .rdata_o(rtr_data_o)
  );

  ihp_drop_ctr #(.W(DROP_W)) u_drop (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hit_i  (in_valid_i && !in_ready_o),
    .count_o(drop_cnt_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_RECV;
      wr_cnt_q <= '0;
      rd_ptr_q <= '0;
      err_q    <= 1'b0;
    end else begin
      err_q <= in_acc && in_last && !dest_ok;
      if (in_acc) begin
        if (in_last) begin
          wr_cnt_q <= '0;
          if (dest_ok) state_q <= ST_DRAIN;  // illegal dest: discard, stay receiving
        end else begin
          wr_cnt_q <= wr_cnt_q + 1'b1;
        end
      end
      if (out_hs) begin
        if (rtr_last_o) begin
          rd_ptr_q <= '0;
          state_q  <= ST_RECV;
        end else begin
          rd_ptr_q <= rd_ptr_q + 1'b1;
        end
      end
    end
  end

  assign rtr_last_o = rtr_valid_o && ({1'b0, rd_ptr_q} == len_m1);
  assign rtr_dest_o = dest[DEST_W-1:0];
  assign rtr_len_o  = len;
  assign dest_err_o = err_q;

  AST_DATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rtr_valid_o && !rtr_ready_i |=> rtr_valid_o && $stable(rtr_data_o)); // R4
  AST_HDR_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rtr_valid_o && !(rtr_ready_i && rtr_last_o) |=> $stable(rtr_dest_o) && $stable(rtr_len_o)); // R2
  AST_HELD_NOT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rtr_valid_o |-> !in_ready_o); // R3
  AST_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rtr_valid_o && rtr_ready_i && rtr_last_o |=> in_ready_o && !rtr_valid_o); // R9
  AST_ERR_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dest_err_o |=> !dest_err_o); // R7
  AST_ERR_NOT_OFFERED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dest_err_o |-> !rtr_valid_o && in_ready_o); // R7
  AST_DEST_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rtr_valid_o |-> dest < PORT_LIM); // R7

endmodule

// File: tb/ingress_hdr_parser_tb_top.sv
`timescale 1ns/1ps
module ingress_hdr_parser_tb_top;

  localparam int NP = 4;

  typedef struct packed {
    logic [7:0]  d;
    logic [1:0]  dst;
    logic [10:0] len;
    logic        last;
  } exp_t;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_ready_o;
  logic        rtr_valid_o;
  logic        rtr_ready = 1'b0;
  logic [7:0]  rtr_data_o;
  logic        rtr_last_o;
  logic [1:0]  rtr_dest_o;
  logic [10:0] rtr_len_o;
  logic        dest_err_o;
  logic [15:0] drop_cnt_o;

  int   n_cmp = 0, n_bad = 0, err_seen = 0, rdy_mode = 0;
  bit   done = 1'b0, err_prev = 1'b0, hold_pend = 1'b0;
  logic [7:0]  hold_data = '0;
  logic [15:0] lfsr = 16'hACE1;
  exp_t exp_q[$];

  always #2.5 clk_i = ~clk_i;

  ingress_hdr_parser dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .in_valid_i(in_valid), .in_data_i(in_data), .in_ready_o(in_ready_o),
    .rtr_valid_o(rtr_valid_o), .rtr_ready_i(rtr_ready), .rtr_data_o(rtr_data_o),
    .rtr_last_o(rtr_last_o), .rtr_dest_o(rtr_dest_o), .rtr_len_o(rtr_len_o),
    .dest_err_o(dest_err_o), .drop_cnt_o(drop_cnt_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // router ready pattern, driven just after the rising edge
  always @(posedge clk_i) begin
    #1;
    case (rdy_mode)
      0:       rtr_ready = 1'b0;
      1:       rtr_ready = 1'b1;
      default: rtr_ready = lfsr[0] ^ lfsr[3];
    endcase
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  end

  // monitor / scoreboard
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      if (dest_err_o) begin
        err_seen++;
        chk(!err_prev, "R7 error pulse width", 2, 1);
      end
      err_prev = dest_err_o;
      if (hold_pend)
        chk(rtr_valid_o && rtr_data_o == hold_data, "R4 data hold under stall",
            int'(rtr_data_o), int'(hold_data));
      hold_pend = rtr_valid_o && !rtr_ready;
      hold_data = rtr_data_o;
      if (rtr_valid_o && rtr_ready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R4 unexpected byte to router", int'(rtr_data_o), -1);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(rtr_data_o == e.d,   "R4 byte order/data", int'(rtr_data_o), int'(e.d));
          chk(rtr_dest_o == e.dst, "R2 destination", int'(rtr_dest_o), int'(e.dst));
          chk(rtr_len_o == e.len,  "R1 length", int'(rtr_len_o), int'(e.len));
          chk(rtr_last_o == e.last, "R5 last flag", int'(rtr_last_o), int'(e.last));
        end
      end
    end
  end

  task automatic send_pkt(input logic [5:0] cmd, input logic [1:0] sz,
                          input logic [7:0] dst, input logic [7:0] src,
                          input logic [7:0] seed);
    int len;
    logic [7:0] b [];
    len = 128 << sz;
    b = new[len];
    for (int i = 0; i < len; i++) begin
      if (i == 0)      b[i] = {cmd, sz};
      else if (i == 1) b[i] = dst;
      else if (i == 2) b[i] = src;
      else             b[i] = 8'(int'(seed) + i * 7);
      if (int'(dst) < NP) exp_q.push_back({b[i], dst[1:0], 11'(len), i == len - 1});
    end
    for (int i = 0; i < len; ) begin
      @(posedge clk_i); #1;
      if (in_ready_o) begin
        in_valid = 1'b1;
        in_data  = b[i];
        i++;
      end else begin
        in_valid = 1'b0;
      end
    end
    @(posedge clk_i); #1;
    in_valid = 1'b0;
  endtask

  task automatic wait_drain();
    for (int k = 0; k < 20000; k++) begin
      @(negedge clk_i);
      if (exp_q.size() == 0 && !rtr_valid_o) break;
    end
  endtask

  initial begin
    int d0, e0;
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    @(negedge clk_i);
    chk(in_ready_o == 1'b1, "R8 reset in_ready", int'(in_ready_o), 1);
    chk(rtr_valid_o == 1'b0, "R8 reset rtr_valid", int'(rtr_valid_o), 0);
    chk(dest_err_o == 1'b0, "R8 reset dest_err", int'(dest_err_o), 0);
    chk(drop_cnt_o == 16'd0, "R8 reset drop count", int'(drop_cnt_o), 0);

    // R1 R2 R4 R5: every size code, varied command bits, random backpressure
    rdy_mode = 1;
    send_pkt(6'h2A, 2'd0, 8'd1, 8'd9, 8'h03);
    wait_drain();
    rdy_mode = 2;
    send_pkt(6'h3F, 2'd1, 8'd3, 8'd0, 8'h51);
    send_pkt(6'h00, 2'd2, 8'd0, 8'd2, 8'h9C);
    send_pkt(6'h15, 2'd3, 8'd2, 8'd1, 8'h27);
    wait_drain();

    // R3 R6: bytes pushed while a packet is held are dropped and counted
    rdy_mode = 0;
    send_pkt(6'h01, 2'd0, 8'd2, 8'd3, 8'h44);
    chk(in_ready_o == 1'b0, "R3 not ready while packet held", int'(in_ready_o), 0);
    d0 = int'(drop_cnt_o);
    in_valid = 1'b1;
    in_data  = 8'hEE;
    repeat (5) begin @(posedge clk_i); #1; end
    in_valid = 1'b0;
    @(negedge clk_i);
    chk(int'(drop_cnt_o) == d0 + 5, "R6 drop count", int'(drop_cnt_o), d0 + 5);
    chk(rtr_valid_o == 1'b1, "R3 packet still offered", int'(rtr_valid_o), 1);
    chk(in_ready_o == 1'b0, "R3 still not ready", int'(in_ready_o), 0);
    rdy_mode = 1;
    wait_drain();

    // R7: illegal destinations
    e0 = err_seen;
    send_pkt(6'h07, 2'd0, 8'd4, 8'd1, 8'h10);
    repeat (3) @(negedge clk_i);
    chk(err_seen == e0 + 1, "R7 error pulse for dest 4", err_seen, e0 + 1);
    chk(rtr_valid_o == 1'b0, "R7 bad packet not offered", int'(rtr_valid_o), 0);
    chk(in_ready_o == 1'b1, "R7 ready after bad packet", int'(in_ready_o), 1);
    send_pkt(6'h08, 2'd1, 8'hFF, 8'd1, 8'h20);
    repeat (3) @(negedge clk_i);
    chk(err_seen == e0 + 2, "R7 error pulse for dest 255", err_seen, e0 + 2);
    chk(rtr_valid_o == 1'b0, "R7 second bad packet not offered", int'(rtr_valid_o), 0);
    send_pkt(6'h09, 2'd0, 8'd3, 8'd0, 8'h30);
    wait_drain();
    chk(err_seen == e0 + 2, "R7 no error on legal packet", err_seen, e0 + 2);

    // R9: new byte in the same cycle as the final drain handshake
    rdy_mode = 1;
    send_pkt(6'h11, 2'd0, 8'd3, 8'd2, 8'h61);
    for (int k = 0; k < 1000; k++) begin
      @(negedge clk_i);
      if (rtr_valid_o && rtr_last_o && rtr_ready) break;
    end
    d0 = int'(drop_cnt_o);
    in_valid = 1'b1;
    in_data  = 8'h5A;
    @(negedge clk_i);
    chk(int'(drop_cnt_o) == d0 + 1, "R9 collision byte dropped", int'(drop_cnt_o), d0 + 1);
    chk(in_ready_o == 1'b1, "R9 ready after final handshake", int'(in_ready_o), 1);
    in_valid = 1'b0;
    send_pkt(6'h12, 2'd0, 8'd0, 8'd1, 8'h73);
    wait_drain();
    chk(exp_q.size() == 0, "R4 all expected bytes delivered", exp_q.size(), 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog R4: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule